// File: doc/BRIEF.md
# PCM Minor-Frame Synchronizer

This block locks onto the minor-frame structure of a serial NRZ-L telemetry stream. It takes one data bit per valid strobe and keeps the most recent bits in a shift register. Each new bit is compared against a programmable sync word, under a bit mask and a programmable pattern length. When the number of differing bits is within tolerance, the block marks a frame boundary. Bits arrive at an arbitrary rate, so nothing moves except on a valid strobe.

A three-state acquisition machine governs the search:
- **Search** examines every bit position. It also accepts the bit-inverted sync word, and on that match it flips the polarity of all later bits.
- **Check** looks for the sync only inside a window of plus or minus a few bits around the spot one frame length after the previous sync. A number of consecutive good frames promotes the machine to Lock.
- **Lock** keeps producing frame strobes at the expected spot when a sync is missed (flywheel). It falls back to Search after a configured number of consecutive misses.

Every frame strobe comes with a status word. The status word gives the new state, a flywheel marker, the polarity flag, the mismatch count at the sync and the bit-slip offset.

Top module: `pcm_frame_sync`

## Requirements
- R1: While reset is asserted and after it is released, `sync_state` is 0 (Search), `frame_start` and `inverted` are 0 and `fq_word` is all zero.
- R2: State, polarity and position change only on cycles where `bit_vld` is high. Any number of idle cycles between bits leaves the result unchanged.
- R3: The compared bits are those set in `cfg_mask` below index `cfg_plen`. Pattern bit `cfg_plen`-1 is the first transmitted bit and bit 0 the last. In Search, a match whose mismatch count is at most `cfg_stol` strobes `frame_start` and moves the state to Check (1).
- R4: In Search, a match of the inverted sync word within `cfg_stol` sets `inverted`. From that point on, every received bit is inverted before it is compared.
- R5: Check moves to Lock (2) on the `cfg_check`-th consecutive accepted frame. A miss in Check returns to Search with no strobe.
- R6: In Check and Lock, a sync is accepted when it completes between `cfg_flen`-`cfg_slip` and `cfg_flen`+`cfg_slip` bits after the previous frame start and has at most `cfg_ltol` mismatches. The next frame is then timed from the accepted sync.
- R7: A miss in Lock raises a flywheel strobe when the window closes, `cfg_slip` bits after the expected position, and keeps the original frame grid. The `cfg_miss`-th consecutive miss returns the state to Search.
- R8: `fq_word` is loaded at each strobe and held until the next one. Its fields are: [1:0] the state after the frame, [2] flywheel, [3] inverted, [10:4] mismatch count, [15:11] slip as a two's-complement offset from the expected position. Flywheel words carry zero count and zero slip.
- R9: `frame_start` is a single-cycle pulse, raised in the cycle after the valid strobe that carried the last sync bit. `sync_state` takes only the values 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Valid strobe for `bit_in` |
| bit_in | input | 1 | Serial stream bit |
| cfg_pattern | input | 64 | Sync word, last bit in bit 0 |
| cfg_mask | input | 64 | Bits of the sync word to compare |
| cfg_plen | input | 7 | Sync word length, 1 to 64 |
| cfg_flen | input | 16 | Frame length in bits |
| cfg_stol | input | 7 | Mismatch tolerance in Search |
| cfg_ltol | input | 7 | Mismatch tolerance in Check and Lock |
| cfg_check | input | 8 | Good frames needed to reach Lock |
| cfg_miss | input | 8 | Consecutive misses that drop Lock |
| cfg_slip | input | 4 | Half-width of the slip window in bits |
| frame_start | output | 1 | Frame boundary strobe |
| sync_state | output | 2 | 0 Search, 1 Check, 2 Lock |
| inverted | output | 1 | Stream polarity is being corrected |
| fq_word | output | 16 | Frame status word |

## Verification
The bench feeds frames one bit early and up to two bits late. A design that mis-sizes the window, or measures the slip against the wrong bit, would drop these frames or report a wrong offset in the status word. A sync damaged by two bits is accepted in Lock. A sync damaged by one bit is refused in Search. A design that uses the wrong tolerance per state would get one of these two cases wrong.

Runs of damaged syncs must produce flywheel strobes exactly `cfg_slip` bits after the expected position, and lock must be lost on the third miss. An off-by-one in the miss counter or in the grid realignment shifts the next strobe. An inverted stream must be recognised and then tracked in the true sense. Masked and out-of-length sync bits must not count as errors. Idle gaps are inserted between bits, so any logic clocked without regard to the valid strobe goes wrong.

// File: rtl/pcmfs_pkg.sv
package pcmfs_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_CHECK  = 2'd1,
    ST_LOCK   = 2'd2
  } sync_st_e;
endpackage

// File: rtl/pcmfs_corr.sv
module pcmfs_corr #(
  parameter int PW  = 64,
  parameter int EW  = $clog2(PW + 1),
  parameter int PLW = $clog2(PW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_vld,
  input  logic           bit_in,
  input  logic           inv,
  input  logic           flip,
  input  logic [PW-1:0]  pattern,
  input  logic [PW-1:0]  mask,
  input  logic [PLW-1:0] plen,
  output logic [EW-1:0]  err_true,
  output logic [EW-1:0]  err_comp
);
  logic [PW-1:0] sr, sr_nxt, emask;

  // enabled compare bits: mask restricted to the programmed length
  always_comb begin
    for (int i = 0; i < PW; i++) begin
      emask[i] = mask[i] & (i < int'(plen));
    end
  end

  assign sr_nxt   = {sr[PW-2:0], bit_in ^ inv};
  assign err_true = EW'($countones((sr_nxt ^ pattern) & emask));
  assign err_comp = EW'($countones((~sr_nxt ^ pattern) & emask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (bit_vld) begin
      sr <= flip ? ~sr_nxt : sr_nxt;
    end
  end

  // R4: polarity flip happens only on a received bit
  p_flip_on_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flip |-> bit_vld);
endmodule

// File: rtl/pcmfs_ctrl.sv
module pcmfs_ctrl
  import pcmfs_pkg::*;
#(
  parameter int EW = 7,
  parameter int LW = 16,
  parameter int SW = 4,
  parameter int CW = 8,
  parameter int QW = 4 + EW + SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic [EW-1:0] err_true,
  input  logic [EW-1:0] err_comp,
  input  logic [LW-1:0] cfg_flen,
  input  logic [SW-1:0] cfg_slip,
  input  logic [EW-1:0] cfg_stol,
  input  logic [EW-1:0] cfg_ltol,
  input  logic [CW-1:0] cfg_check,
  input  logic [CW-1:0] cfg_miss,
  output logic          flip,
  output logic          inv,
  output logic [1:0]    state,
  output logic          frame_start,
  output logic [QW-1:0] fq
);
  sync_st_e      st, st_n;
  logic [LW:0]   pos, pos_n, p1, lo, hi, flen_x, slip_x;
  logic [CW-1:0] good, good_n, miss, miss_n;
  logic [CW:0]   good_inc, miss_inc;
  logic          inv_n, fs_n, in_win, at_end, hit_t, hit_c;
  logic [EW-1:0] tol;
  logic [SW:0]   soff;
  logic [QW-1:0] fq_n;

  function automatic logic [QW-1:0] mkq(logic [1:0] s, logic fly, logic iv,
                                        logic [EW-1:0] e, logic [SW:0] so);
    return {so, e, iv, fly, s};
  endfunction

  assign flen_x   = (LW+1)'(cfg_flen);
  assign slip_x   = (LW+1)'(cfg_slip);
  assign p1       = pos + (LW+1)'(1);
  assign lo       = flen_x - slip_x;
  assign hi       = flen_x + slip_x;
  assign in_win   = (p1 >= lo) && (p1 <= hi);
  assign at_end   = (p1 == hi);
  assign soff     = (SW+1)'(p1 - flen_x);
  assign tol      = (st == ST_SEARCH) ? cfg_stol : cfg_ltol;
  assign hit_t    = (err_true <= tol);
  assign hit_c    = (err_comp <= cfg_stol);
  assign good_inc = {1'b0, good} + (CW+1)'(1);
  assign miss_inc = {1'b0, miss} + (CW+1)'(1);

  always_comb begin
    st_n   = st;
    pos_n  = pos;
    good_n = good;
    miss_n = miss;
    inv_n  = inv;
    fs_n   = 1'b0;
    fq_n   = fq;
    flip   = 1'b0;
    if (bit_vld) begin
      if (st == ST_SEARCH) begin
        if (hit_t || hit_c) begin
          flip   = !hit_t;
          inv_n  = inv ^ !hit_t;
          st_n   = ST_CHECK;
          pos_n  = '0;
          good_n = '0;
          fs_n   = 1'b1;
          fq_n   = mkq(ST_CHECK, 1'b0, inv ^ !hit_t,
                       hit_t ? err_true : err_comp, '0);
        end
      end else if (in_win && hit_t) begin
        pos_n = '0;
        fs_n  = 1'b1;
        if (st == ST_CHECK) begin
          if (good_inc >= {1'b0, cfg_check}) begin
            st_n   = ST_LOCK;
            good_n = '0;
            miss_n = '0;
          end else begin
            good_n = good_inc[CW-1:0];
          end
        end else begin
          miss_n = '0;
        end
        fq_n = mkq(st_n, 1'b0, inv, err_true, soff);
      end else if (at_end) begin
        if (st == ST_CHECK) begin
          st_n  = ST_SEARCH;
          pos_n = '0;
        end else begin
          fs_n  = 1'b1;
          pos_n = slip_x;
          if (miss_inc >= {1'b0, cfg_miss}) begin
            st_n   = ST_SEARCH;
            miss_n = '0;
          end else begin
            miss_n = miss_inc[CW-1:0];
          end
          fq_n = mkq(st_n, 1'b1, inv, '0, '0);
        end
      end else begin
        pos_n = p1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_SEARCH;
      pos         <= '0;
      good        <= '0;
      miss        <= '0;
      inv         <= 1'b0;
      frame_start <= 1'b0;
      fq          <= '0;
    end else begin
      st          <= st_n;
      pos         <= pos_n;
      good        <= good_n;
      miss        <= miss_n;
      inv         <= inv_n;
      frame_start <= fs_n;
      fq          <= fq_n;
    end
  end

  assign state = st;

  logic signed [SW+1:0] q_slip, w_slip;
  assign q_slip = {fq[QW-1], fq[QW-1 -: SW+1]};
  assign w_slip = {2'b00, cfg_slip};

  // R2: nothing moves without a valid bit
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(st) && $stable(inv) && !frame_start);
  // R4: polarity changes only out of Search
  p_inv_from_search_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inv) |-> $past(st) == ST_SEARCH);
  // R5: Lock is never entered straight from Search
  p_no_skip_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_SEARCH |=> st != ST_LOCK);
  // R6: reported slip stays inside the window
  p_slip_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (q_slip <= w_slip) && (q_slip >= -w_slip));
  // R9: strobe follows a received bit, state encoding legal
  p_strobe_after_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(bit_vld));
  p_state_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);
endmodule

// File: rtl/pcm_frame_sync.sv
module pcm_frame_sync
  import pcmfs_pkg::*;
#(
  parameter int PW = 64,
  parameter int LW = 16,
  parameter int SW = 4,
  parameter int CW = 8,
  localparam int EW  = $clog2(PW + 1),
  localparam int PLW = $clog2(PW + 1),
  localparam int QW  = 4 + EW + SW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_vld,
  input  logic           bit_in,
  input  logic [PW-1:0]  cfg_pattern,
  input  logic [PW-1:0]  cfg_mask,
  input  logic [PLW-1:0] cfg_plen,
  input  logic [LW-1:0]  cfg_flen,
  input  logic [EW-1:0]  cfg_stol,
  input  logic [EW-1:0]  cfg_ltol,
  input  logic [CW-1:0]  cfg_check,
  input  logic [CW-1:0]  cfg_miss,
  input  logic [SW-1:0]  cfg_slip,
  output logic           frame_start,
  output logic [1:0]     sync_state,
  output logic           inverted,
  output logic [QW-1:0]  fq_word
);
  logic [EW-1:0] err_true, err_comp;
  logic          flip;

  pcmfs_corr #(.PW(PW), .EW(EW), .PLW(PLW)) u_corr (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .inv(inverted), .flip(flip), .pattern(cfg_pattern), .mask(cfg_mask),
    .plen(cfg_plen), .err_true(err_true), .err_comp(err_comp)
  );

  pcmfs_ctrl #(.EW(EW), .LW(LW), .SW(SW), .CW(CW), .QW(QW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld),
    .err_true(err_true), .err_comp(err_comp),
    .cfg_flen(cfg_flen), .cfg_slip(cfg_slip), .cfg_stol(cfg_stol),
    .cfg_ltol(cfg_ltol), .cfg_check(cfg_check), .cfg_miss(cfg_miss),
    .flip(flip), .inv(inverted), .state(sync_state),
    .frame_start(frame_start), .fq(fq_word)
  );
endmodule

// File: tb/sim_pcm_frame_sync.sv
`timescale 1ns/1ps
module sim_pcm_frame_sync;
  localparam logic [15:0] PAT = 16'hEB90;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_vld, bit_in;
  logic [63:0] cfg_pattern, cfg_mask;
  logic [6:0]  cfg_plen, cfg_stol, cfg_ltol;
  logic [15:0] cfg_flen;
  logic [7:0]  cfg_check, cfg_miss;
  logic [3:0]  cfg_slip;
  logic        frame_start, inverted;
  logic [1:0]  sync_state;
  logic [15:0] fq_word;

  int nchk = 0, nfail = 0, nbits = 0;
  logic [15:0] fq_a;
  logic [1:0]  st_a;
  bit done = 0;

  always #2 clk = ~clk;

  pcm_frame_sync u0 (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .cfg_pattern(cfg_pattern), .cfg_mask(cfg_mask), .cfg_plen(cfg_plen),
    .cfg_flen(cfg_flen), .cfg_stol(cfg_stol), .cfg_ltol(cfg_ltol),
    .cfg_check(cfg_check), .cfg_miss(cfg_miss), .cfg_slip(cfg_slip),
    .frame_start(frame_start), .sync_state(sync_state),
    .inverted(inverted), .fq_word(fq_word)
  );

  function automatic logic [15:0] expq(int s, int fly, int iv, int e, int sl);
    return 16'(((sl & 31) << 11) | (e << 4) | (iv << 3) | (fly << 2) | s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [63:0] msk, input int plen);
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    cfg_pattern = 64'(PAT); cfg_mask = msk; cfg_plen = 7'(plen);
    cfg_flen = 16'd64; cfg_stol = 7'd0; cfg_ltol = 7'd2;
    cfg_check = 8'd2; cfg_miss = 8'd3; cfg_slip = 4'd2;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic b, output logic fs, output logic [15:0] q,
                          output logic [1:0] s);
    repeat (nbits % 3) @(posedge clk);
    nbits++;
    @(negedge clk); bit_vld = 1'b1; bit_in = b;
    @(posedge clk); #1;
    bit_vld = 1'b0;
    fs = frame_start; q = fq_word; s = sync_state;
  endtask

  // nz data bits, then the 16-bit sync with its first nerr bits flipped;
  // strobes expected only at indices ia and ib
  task automatic frame(input int nz, input int nerr, input bit iv,
                       input int ia, input int ib, input string req);
    int bad = -1;
    logic fs, b, e;
    logic [15:0] q;
    logic [1:0] s;
    for (int i = 0; i < nz + 16; i++) begin
      b = (i < nz) ? 1'b0 : PAT[15 - (i - nz)];
      if (i >= nz && (i - nz) < nerr) b = ~b;
      send_bit(b ^ iv, fs, q, s);
      e = (i == ia) || (i == ib);
      if (fs !== e && bad < 0) bad = i;
      if (i == ia) begin fq_a = q; st_a = s; end
    end
    chk({req, " strobe placement (first wrong bit index)"}, 32'(bad), 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset({64{1'b1}}, 16);
    // R1 reset state
    chk("R1 state", 32'(sync_state), 0);
    chk("R1 strobe", 32'(frame_start), 0);
    chk("R1 inverted", 32'(inverted), 0);
    chk("R1 fq", 32'(fq_word), 0);

    // R3 search acquisition, R9 strobe on last sync bit
    frame(48, 0, 0, 63, -1, "R3");
    chk("R3 state", 32'(sync_state), 1);
    chk("R8 fq search hit", 32'(fq_word), 32'(expq(1,0,0,0,0)));
    // R5 two good frames to lock
    frame(48, 0, 0, 63, -1, "R5");
    chk("R5 still check", 32'(sync_state), 1);
    frame(48, 0, 0, 63, -1, "R5");
    chk("R5 lock", 32'(sync_state), 2);
    chk("R8 fq lock", 32'(fq_word), 32'(expq(2,0,0,0,0)));
    // R6 lock tolerance 2
    frame(48, 2, 0, 63, -1, "R6 err2");
    chk("R6 err count", 32'(fq_word), 32'(expq(2,0,0,2,0)));
    // R6 slips
    frame(47, 0, 0, 62, -1, "R6 early");
    chk("R6 slip -1", 32'(fq_word), 32'(expq(2,0,0,0,-1)));
    frame(50, 0, 0, 65, -1, "R6 late");
    chk("R6 slip +2", 32'(fq_word), 32'(expq(2,0,0,0,2)));
    frame(48, 0, 0, 63, -1, "R6 regrid");
    chk("R6 slip 0", 32'(fq_word), 32'(expq(2,0,0,0,0)));
    // R7 single miss: flywheel then recovery on original grid
    frame(48, 3, 0, -1, -1, "R7 miss");
    frame(48, 0, 0, 1, 63, "R7 flywheel");
    chk("R7 flywheel word", 32'(fq_a), 32'(expq(2,1,0,0,0)));
    chk("R7 flywheel state", 32'(st_a), 2);
    chk("R7 relock", 32'(sync_state), 2);
    // R7 three misses drop lock, then search reacquires
    frame(48, 3, 0, -1, -1, "R7 m1");
    frame(48, 3, 0, 1, -1, "R7 m2");
    frame(48, 3, 0, 1, -1, "R7 m3");
    frame(48, 0, 0, 1, 63, "R7 drop");
    chk("R7 drop word", 32'(fq_a), 32'(expq(0,1,0,0,0)));
    chk("R7 drop state", 32'(st_a), 0);
    chk("R3 reacquire", 32'(sync_state), 1);
    // R5 miss in check returns to search silently; R3 search tol tighter
    frame(48, 3, 0, -1, -1, "R5 check miss");
    frame(48, 1, 0, -1, -1, "R3 tol");
    chk("R3 one error refused", 32'(sync_state), 0);
    // R4 inverted stream
    frame(48, 0, 1, 63, -1, "R4");
    chk("R4 inverted", 32'(inverted), 1);
    chk("R4 fq", 32'(fq_word), 32'(expq(1,0,1,0,0)));
    frame(48, 0, 1, 63, -1, "R4 track");
    frame(48, 0, 1, 63, -1, "R4 track");
    chk("R4 lock inverted", 32'(fq_word), 32'(expq(2,0,1,0,0)));
    // R2 idle cycles
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(posedge clk); #1;
        if (frame_start !== 1'b0 || sync_state !== 2'd2) seen++;
      end
      chk("R2 idle stable", 32'(seen), 0);
    end
    frame(48, 0, 1, 63, -1, "R2 resume");
    // R3 mask: first sync bit masked
    do_reset(64'h7FFF, 16);
    frame(48, 1, 0, 63, -1, "R3 mask");
    chk("R3 mask state", 32'(sync_state), 1);
    // R3 length: only 12 low bits compared
    do_reset({64{1'b1}}, 12);
    frame(48, 4, 0, 63, -1, "R3 plen");
    chk("R3 plen state", 32'(sync_state), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule